// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-ported word memory and settles same-word collisions between its left and right ports. Each port presents an active-low chip enable, a read/write strobe (low means write) and a 14-bit word address. When both ports are enabled on the same word, the block picks one of them. It then drives an active-low busy flag toward the other port, and that flag also stops the other port's writes from reaching the array.

A role input selects how the busy flags are used. In master role the block arbitrates and drives its busy outputs. Those outputs can be wired to further devices that run in slave role, so that a wide memory built from several slices follows a single arbitration result. In slave role the busy outputs are held inactive. The block takes busy flags from outside on its busy inputs and uses them only to inhibit writes. The block produces one write-permit output per port, and the array uses it as its write enable. Everything is synchronous to one clock.

Top module: `dp_contention_arbiter`

## Requirements
- R1: After reset, and before any contention has been sampled, both busy outputs are high. A port that is enabled with its strobe low has its write permit high.
- R2: No busy output goes low unless both chip enables were low and both addresses were equal at the previous clock edge.
- R3: When one port already held its enabled address at the edge before the match and the other port has just arrived, the port that was there first wins. Busy goes low only toward the newcomer.
- R4: When both ports reach the matching state at the same edge, the left port wins, and only the right busy output goes low.
- R5: A busy output changes one clock after the edge at which the contention condition was sampled. In the first matching cycle both busy outputs are still high.
- R6: Busy toward the loser returns high one clock after the edge at which the addresses differ or either chip enable is high.
- R7: While the match continues, the winner keeps its grant, whatever the loser does with its strobe.
- R8: A write permit is high exactly when that port's chip enable is low, its strobe is low (write) and the busy that applies to that port is inactive. Reads never raise it.
- R9: With the role input low (slave), both busy outputs stay high. The busy that applies to each port is that port's busy input, and internal arbitration has no effect on the permits.
- R10: With the role input high (master), the busy inputs are ignored. The busy that applies to each port is its own busy output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | 1 = arbitrate and drive busy, 0 = follow busy inputs |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_wr_n | input | 1 | Left strobe, 0 = write, 1 = read |
| l_addr | input | 14 | Left word address |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_wr_n | input | 1 | Right strobe, 0 = write, 1 = read |
| r_addr | input | 14 | Right word address |
| l_busy_in_n | input | 1 | External busy toward left, used in slave role |
| r_busy_in_n | input | 1 | External busy toward right, used in slave role |
| l_busy_out_n | output | 1 | Busy toward left, active low, registered |
| r_busy_out_n | output | 1 | Busy toward right, active low, registered |
| l_wr_ok | output | 1 | Left write permit to the array |
| r_wr_ok | output | 1 | Right write permit to the array |

## Verification
Directed sequences check four cases: a left port settled before the right arrives, the reverse order, both ports arriving at the same edge, and a contention at the moment reset is released. Between them these show that first-arrival ordering is kept apart from the left-wins tie rule. Release is checked both by an address change and by a chip enable going high, and the loser's strobe is toggled during a held contention to show that the grant does not move. Slave-role runs drive the external busy inputs against live internal contention, and master-role runs drive them with no contention. Together these separate the two sources of write inhibit. Random cycles over four high-end addresses, mixed strobes, roles and busy inputs are then checked against a cycle model in the bench.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
    } arb_state_t;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned P_LEFT    = 0;
    localparam int unsigned P_RIGHT   = 1;

endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              held
);
    typedef struct packed {
        logic              ce_n;
        logic [ADDR_W-1:0] addr;
    } track_t;

    track_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.ce_n = ce_n;
        trk_d.addr = addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{ce_n: 1'b1, addr: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    // Port was already enabled on this same word at the previous edge.
    assign held = !ce_n && !trk_q.ce_n && (addr == trk_q.addr);

endmodule

// File: rtl/dpa_arb_core.sv
module dpa_arb_core
    import dpa_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   match,
    input  logic   left_held,
    input  logic   right_held,
    output owner_e owner_q
);
    arb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!match) begin
            st_d.owner = OWN_NONE;
        end else if (st_q.owner == OWN_NONE) begin
            // First arrival wins; a same-edge arrival goes to the left port.
            st_d.owner = (right_held && !left_held) ? OWN_RIGHT : OWN_LEFT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign owner_q = st_q.owner;

endmodule

// File: rtl/dpa_port_gate.sv
module dpa_port_gate (
    input  logic is_master,
    input  logic lost,
    input  logic busy_in_n,
    input  logic ce_n,
    input  logic wr_n,
    output logic busy_out_n,
    output logic wr_ok
);
    logic blocked;

    always_comb begin
        busy_out_n = is_master ? !lost : 1'b1;
        blocked    = is_master ? lost : !busy_in_n;
        wr_ok      = !ce_n && !wr_n && !blocked;
    end

endmodule

// File: rtl/dp_contention_arbiter.sv
module dp_contention_arbiter
    import dpa_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              l_ce_n,
    input  logic              l_wr_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce_n,
    input  logic              r_wr_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_out_n,
    output logic              r_busy_out_n,
    output logic              l_wr_ok,
    output logic              r_wr_ok
);
    logic [ADDR_W-1:0] addr_v   [NUM_PORTS];
    logic              ce_v     [NUM_PORTS];
    logic              wr_v     [NUM_PORTS];
    logic              bin_v    [NUM_PORTS];
    logic              bout_v   [NUM_PORTS];
    logic              ok_v     [NUM_PORTS];
    logic              held_v   [NUM_PORTS];
    logic              lost_v   [NUM_PORTS];
    logic              match;
    owner_e            owner;

    always_comb begin
        addr_v[P_LEFT]  = l_addr;
        addr_v[P_RIGHT] = r_addr;
        ce_v[P_LEFT]    = l_ce_n;
        ce_v[P_RIGHT]   = r_ce_n;
        wr_v[P_LEFT]    = l_wr_n;
        wr_v[P_RIGHT]   = r_wr_n;
        bin_v[P_LEFT]   = l_busy_in_n;
        bin_v[P_RIGHT]  = r_busy_in_n;
        lost_v[P_LEFT]  = (owner == OWN_RIGHT);
        lost_v[P_RIGHT] = (owner == OWN_LEFT);
        match           = !l_ce_n && !r_ce_n && (l_addr == r_addr);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpa_port_track #(.ADDR_W(ADDR_W)) i_track (
            .clk   (clk),
            .rst_n (rst_n),
            .ce_n  (ce_v[p]),
            .addr  (addr_v[p]),
            .held  (held_v[p])
        );

        dpa_port_gate i_gate (
            .is_master  (is_master),
            .lost       (lost_v[p]),
            .busy_in_n  (bin_v[p]),
            .ce_n       (ce_v[p]),
            .wr_n       (wr_v[p]),
            .busy_out_n (bout_v[p]),
            .wr_ok      (ok_v[p])
        );
    end

    dpa_arb_core i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .match      (match),
        .left_held  (held_v[P_LEFT]),
        .right_held (held_v[P_RIGHT]),
        .owner_q    (owner)
    );

    assign l_busy_out_n = bout_v[P_LEFT];
    assign r_busy_out_n = bout_v[P_RIGHT];
    assign l_wr_ok      = ok_v[P_LEFT];
    assign r_wr_ok      = ok_v[P_RIGHT];

endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
    parameter int unsigned ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              is_master,
    input logic              l_ce_n,
    input logic              r_ce_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_in_n,
    input logic              r_busy_in_n,
    input logic              l_busy_out_n,
    input logic              r_busy_out_n,
    input logic              l_wr_ok,
    input logic              r_wr_ok
);
    logic same_word;
    assign same_word = !l_ce_n && !r_ce_n && (l_addr == r_addr);

    // R2 / R6: no sampled match means both flags high after the edge
    a_r6_release_after_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        !same_word |=> (l_busy_out_n && r_busy_out_n));

    // R3: never both ports flagged at once
    a_r3_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_out_n && !r_busy_out_n));

    // R5: a fresh match in master role flags somebody one clock later
    a_r5_flag_next_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && same_word && l_busy_out_n && r_busy_out_n)
        |=> (!is_master || !l_busy_out_n || !r_busy_out_n));

    // R7: the loser stays flagged while the match holds
    a_r7_grant_held_right: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && same_word && !r_busy_out_n) |=> (!is_master || !r_busy_out_n));
    a_r7_grant_held_left: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && same_word && !l_busy_out_n) |=> (!is_master || !l_busy_out_n));

    // R8: a flagged port never writes
    a_r8_loser_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_out_n |-> !l_wr_ok) and (!r_busy_out_n |-> !r_wr_ok));

    // R9: slave role keeps outputs quiet and obeys external busy
    a_r9_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (l_busy_out_n && r_busy_out_n));
    a_r9_slave_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && (!l_busy_in_n || !r_busy_in_n))
        |-> ((l_busy_in_n || !l_wr_ok) && (r_busy_in_n || !r_wr_ok)));

endmodule

bind dp_contention_arbiter dpa_checker #(.ADDR_W(ADDR_W)) i_dpa_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .is_master    (is_master),
    .l_ce_n       (l_ce_n),
    .r_ce_n       (r_ce_n),
    .l_addr       (l_addr),
    .r_addr       (r_addr),
    .l_busy_in_n  (l_busy_in_n),
    .r_busy_in_n  (r_busy_in_n),
    .l_busy_out_n (l_busy_out_n),
    .r_busy_out_n (r_busy_out_n),
    .l_wr_ok      (l_wr_ok),
    .r_wr_ok      (r_wr_ok)
);

// File: tb/test_dp_contention_arbiter.sv
module test_dp_contention_arbiter;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          is_master = 1'b1;
    logic          l_ce_n = 1'b1, l_wr_n = 1'b1, r_ce_n = 1'b1, r_wr_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic          l_busy_out_n, r_busy_out_n, l_wr_ok, r_wr_ok;

    int total = 0;
    int bad   = 0;

    // reference model state: 0 none, 1 left owns, 2 right owns
    int            m_owner = 0;
    logic          m_plce = 1'b1, m_prce = 1'b1;
    logic [AW-1:0] m_pla = '0, m_pra = '0;

    always #4 clk = ~clk;

    dp_contention_arbiter #(.ADDR_W(AW)) i_dp_contention_arbiter (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .l_ce_n(l_ce_n), .l_wr_n(l_wr_n), .l_addr(l_addr),
        .r_ce_n(r_ce_n), .r_wr_n(r_wr_n), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
        .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
    );

    function automatic logic exp_lbusy();
        return is_master ? (m_owner != 2) : 1'b1;
    endfunction
    function automatic logic exp_rbusy();
        return is_master ? (m_owner != 1) : 1'b1;
    endfunction
    function automatic logic exp_lok();
        logic blk;
        blk = is_master ? (m_owner == 2) : !l_busy_in_n;
        return !l_ce_n && !l_wr_n && !blk;
    endfunction
    function automatic logic exp_rok();
        logic blk;
        blk = is_master ? (m_owner == 1) : !r_busy_in_n;
        return !r_ce_n && !r_wr_n && !blk;
    endfunction

    task automatic model_edge();
        logic mt, lh, rh;
        mt = !l_ce_n && !r_ce_n && (l_addr == r_addr);
        lh = !l_ce_n && !m_plce && (l_addr == m_pla);
        rh = !r_ce_n && !m_prce && (r_addr == m_pra);
        if (!mt) m_owner = 0;
        else if (m_owner == 0) m_owner = (rh && !lh) ? 2 : 1;
        m_plce = l_ce_n; m_pla = l_addr;
        m_prce = r_ce_n; m_pra = r_addr;
    endtask

    task automatic chk1(input string tag, input string nm, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk1(tag, "l_busy_out_n", l_busy_out_n, exp_lbusy());
        chk1(tag, "r_busy_out_n", r_busy_out_n, exp_rbusy());
        chk1(tag, "l_wr_ok", l_wr_ok, exp_lok());
        chk1(tag, "r_wr_ok", r_wr_ok, exp_rok());
    endtask

    // drive at negedge, check, then let the edge happen and update the model
    task automatic cyc(input string tag, input logic m,
                       input logic lc, input logic lw, input logic [AW-1:0] la,
                       input logic rc, input logic rw, input logic [AW-1:0] ra,
                       input logic lb, input logic rb);
        @(negedge clk);
        is_master = m; l_ce_n = lc; l_wr_n = lw; l_addr = la;
        r_ce_n = rc; r_wr_n = rw; r_addr = ra; l_busy_in_n = lb; r_busy_in_n = rb;
        #1;
        check_all(tag);
        @(posedge clk);
        model_edge();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // reset with a contention already present on the ports
        l_ce_n = 1'b0; r_ce_n = 1'b0; l_wr_n = 1'b0; r_wr_n = 1'b0;
        l_addr = 14'h0040; r_addr = 14'h0040;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: idle flags, writes allowed before first sampled edge
        chk1("R1", "l_busy_out_n", l_busy_out_n, 1'b1);
        chk1("R1", "r_busy_out_n", r_busy_out_n, 1'b1);
        chk1("R1", "l_wr_ok", l_wr_ok, 1'b1);
        chk1("R1", "r_wr_ok", r_wr_ok, 1'b1);
        rst_n = 1'b1;
        @(posedge clk);
        model_edge();
        // R4: neither was held before reset release, so left wins
        cyc("R4", 1, 0, 0, 14'h0040, 0, 0, 14'h0040, 1, 1);
        @(negedge clk); #1;
        chk1("R4", "r_busy_out_n", r_busy_out_n, 1'b0);
        chk1("R4", "l_busy_out_n", l_busy_out_n, 1'b1);

        // R6: release by chip enable
        cyc("R6", 1, 0, 0, 14'h0040, 1, 0, 14'h0040, 1, 1);
        cyc("R6", 1, 0, 0, 14'h0040, 1, 0, 14'h0040, 1, 1);
        // R2: enabled on different words, and same word with one disabled
        cyc("R2", 1, 0, 0, 14'h0005, 0, 0, 14'h0006, 1, 1);
        cyc("R2", 1, 0, 0, 14'h0005, 0, 0, 14'h0006, 1, 1);
        cyc("R2", 1, 0, 0, 14'h0006, 1, 0, 14'h0006, 1, 1);
        cyc("R2", 1, 1, 0, 14'h0006, 0, 0, 14'h0006, 1, 1);

        // R3: left settled first, right arrives
        cyc("R3", 1, 0, 1, 14'h000A, 1, 1, 14'h0000, 1, 1);
        cyc("R5", 1, 0, 1, 14'h000A, 0, 0, 14'h000A, 1, 1);
        @(negedge clk); #1;
        chk1("R3", "r_busy_out_n", r_busy_out_n, 1'b0);
        chk1("R8", "r_wr_ok", r_wr_ok, 1'b0);
        // R7: loser toggles its strobe, grant stays with left
        cyc("R7", 1, 0, 0, 14'h000A, 0, 1, 14'h000A, 1, 1);
        cyc("R7", 1, 0, 0, 14'h000A, 0, 0, 14'h000A, 1, 1);
        cyc("R8", 1, 0, 1, 14'h000A, 0, 0, 14'h000A, 1, 1);
        // R6: release by address change
        cyc("R6", 1, 0, 0, 14'h000A, 0, 0, 14'h000B, 1, 1);
        cyc("R6", 1, 0, 0, 14'h000A, 0, 0, 14'h000B, 1, 1);

        // R3: right settled first, left arrives
        cyc("R3", 1, 0, 0, 14'h0100, 0, 0, 14'h3FFF, 1, 1);
        cyc("R3", 1, 0, 0, 14'h3FFF, 0, 0, 14'h3FFF, 1, 1);
        cyc("R3", 1, 0, 0, 14'h3FFF, 0, 0, 14'h3FFF, 1, 1);
        @(negedge clk); #1;
        chk1("R3", "l_busy_out_n", l_busy_out_n, 1'b0);
        chk1("R3", "r_wr_ok", r_wr_ok, 1'b1);
        cyc("R6", 1, 1, 0, 14'h3FFF, 0, 0, 14'h3FFF, 1, 1);

        // R4: both move to the same word at the same edge
        cyc("R4", 1, 0, 0, 14'h0030, 0, 0, 14'h0031, 1, 1);
        cyc("R4", 1, 0, 0, 14'h0032, 0, 0, 14'h0032, 1, 1);
        cyc("R4", 1, 0, 0, 14'h0032, 0, 0, 14'h0032, 1, 1);

        // R10: master ignores external busy inputs
        cyc("R10", 1, 0, 0, 14'h0001, 0, 0, 14'h0002, 0, 0);
        cyc("R10", 1, 0, 0, 14'h0001, 0, 0, 14'h0002, 0, 0);
        @(negedge clk); #1;
        chk1("R10", "l_wr_ok", l_wr_ok, 1'b1);

        // R9: slave role with live internal contention and external busy
        cyc("R9", 0, 0, 0, 14'h0077, 0, 0, 14'h0077, 0, 1);
        cyc("R9", 0, 0, 0, 14'h0077, 0, 0, 14'h0077, 0, 1);
        cyc("R9", 0, 0, 0, 14'h0077, 0, 0, 14'h0077, 1, 0);
        @(negedge clk); #1;
        chk1("R9", "l_busy_out_n", l_busy_out_n, 1'b1);
        chk1("R9", "l_wr_ok", l_wr_ok, 1'b1);
        chk1("R9", "r_wr_ok", r_wr_ok, 1'b0);
        // R8: reads never raise the permit
        cyc("R8", 1, 0, 1, 14'h0009, 0, 1, 14'h0008, 1, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            cyc("RND", ($urandom % 8) != 0,
                ($urandom % 5) == 0, $urandom % 2, 14'h3FFC + 14'($urandom % 4),
                ($urandom % 5) == 0, $urandom % 2, 14'h3FFC + 14'($urandom % 4),
                ($urandom % 3) != 0, ($urandom % 3) != 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule